// File: doc/BRIEF.md
# Single-Cell Charge Cycle Controller

This block is the sequencing core of a single-cell lithium battery charger. It decides when charging may run, at which of two current levels (a reduced conditioning level of one tenth of the full rate, or the full fast rate), when the cell counts as full, when a full cell needs topping up again, and what happens when a safety timer runs out. The analog side supplies already deglitched comparator flags: cell above the low-voltage threshold, cell below the recharge threshold, and charge current below the termination level. It also supplies a master enable, a suspend request and a periodic time tick. The regulation loops act on the level select and charge-on outputs.

The states are: IDLE (enable low), WAIT (start-up delay after enable rises), RESTART (one cycle that opens a new charge cycle and clears the safety timer), PRE (conditioning current), FAST_CC (full rate, cell below the recharge threshold), CV (full rate, cell near regulation voltage, termination being qualified), DONE (cell full), FLT_LO (timer fault with the cell below the recharge threshold and the fault current applied), FLT_HI (timer fault with the cell above the threshold) and DET (one-cycle battery-detection request).

The transitions are:
- IDLE to WAIT when enable is high.
- WAIT to RESTART after the start delay.
- RESTART to PRE or FAST_CC, chosen by the filtered low-voltage flag.
- PRE to FAST_CC and FAST_CC/CV back to PRE when the filtered low-voltage flag changes.
- FAST_CC to CV when the cell rises above the recharge threshold, and CV back to FAST_CC when it falls below it.
- CV to DONE on qualified termination.
- DONE to RESTART on the recharge flag.
- PRE, FAST_CC and CV to FLT_LO or FLT_HI on a timeout.
- FLT_LO to FLT_HI when the cell rises above the recharge threshold.
- FLT_HI to DET when the cell falls below the recharge threshold.
- DET to RESTART.
- Any state to IDLE when enable is low.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: After reset every output is 0 and the controller sits in IDLE.
- R2: After the enable input rises, charge-on stays 0 until START_DLY ticks have been counted in WAIT; the cycle then opens through RESTART.
- R3: The level select is 0 (conditioning, one tenth rate) while the filtered low-voltage flag is 0 and 1 (fast) while it is 1. The flag only follows the raw input after LOWV_DWELL consecutive ticks on which the raw input differs, so a shorter pulse changes nothing.
- R4: If PRE lasts PRE_LIMIT unsuspended ticks, the controller enters a timer fault: fault flag 1 and charge-on 0.
- R5: In FAST_CC and CV, with timer mode 2'b01 or 2'b10, a timer fault occurs once fast_limit_i unsuspended ticks have elapsed since the fast phase began. While suspend_i is 1 the count holds and charge-on is 0.
- R6: Termination requires the cell above the recharge threshold and the current below the termination level. This condition is filtered by TERM_DEG ticks on both edges, and the filtered condition must then hold for TERM_QUAL ticks in CV. The controller then enters DONE: done 1, charge-on 0.
- R7: Timer mode 2'b00 holds the fast timer cleared and blocks termination. Timer mode 2'b11 disables the fast-timer fault but keeps termination.
- R8: From DONE, a set recharge flag opens a new cycle through RESTART without the start delay.
- R9: In FLT_HI, a fall below the recharge threshold clears the fault. It then raises the detection request for exactly one cycle and opens a new cycle.
- R10: A timeout with the cell below the recharge threshold enters FLT_LO, which asserts the fault-current output. A rise above the threshold drops the fault current and continues as in R9.
- R11: Enable low moves the controller to IDLE at the next clock from any state. Raising enable again starts a new cycle with the start delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| tick_i | input | 1 | Time base strobe, one per time unit |
| chg_en_i | input | 1 | Master charge enable |
| suspend_i | input | 1 | Charge suspend (temperature etc.), pauses timers |
| bat_above_lowv_i | input | 1 | Cell above low-voltage threshold (raw) |
| bat_below_rech_i | input | 1 | Cell below recharge threshold (deglitched) |
| i_below_term_i | input | 1 | Charge current below termination level |
| tmr_mode_i | input | 2 | 00 timer+termination off, 01/10 normal, 11 timer off |
| fast_limit_i | input | FAST_W | Fast-charge timer limit in ticks |
| lvl_fast_o | output | 1 | Current level: 0 conditioning, 1 fast |
| chg_on_o | output | 1 | Charge enable to the regulation loops |
| done_o | output | 1 | Charge complete |
| tmr_fault_o | output | 1 | Safety timer fault |
| fault_cur_o | output | 1 | Apply small fault current |
| det_req_o | output | 1 | Battery detection request pulse |

## Verification
On every cycle the assertions check several rules. Charge-on is never set together with done, a fault or suspend. The fault current only appears with a fault, and the detection request never lasts two cycles. An enable drop reaches IDLE at once, and charge-on stays low right after enable rises. Done never rises shortly after timer mode 00. Dwell lengths, timeout counts, the pause under suspend, recharge without delay and the two fault-recovery paths depend on long input histories. Only the bench scenarios show these, comparing against a tick-accurate model built from the requirements.

// File: rtl/chg_cycle_pkg.sv
package chg_cycle_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESTART,
        ST_PRE,
        ST_FAST_CC,
        ST_CV,
        ST_DONE,
        ST_FLT_LO,
        ST_FLT_HI,
        ST_DET
    } cyc_state_e;

    localparam logic [1:0] TM_ALL_OFF  = 2'b00;
    localparam logic [1:0] TM_TMR_OFF  = 2'b11;

endpackage

// File: rtl/dwell_filter.sv
module dwell_filter #(
    parameter int N    = 25,
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o <= INIT;
            cnt_q  <= '0;
        end else if (raw_i == filt_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                filt_o <= raw_i;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (run_i && (cnt_o != {W{1'b1}})) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
    import chg_cycle_pkg::*;
#(
    parameter int START_DLY  = 1500,
    parameter int PRE_LIMIT  = 1800000,
    parameter int LOWV_DWELL = 25,
    parameter int TERM_DEG   = 100,
    parameter int TERM_QUAL  = 250,
    parameter int FAST_W     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              chg_en_i,
    input  logic              suspend_i,
    input  logic              bat_above_lowv_i,
    input  logic              bat_below_rech_i,
    input  logic              i_below_term_i,
    input  logic [1:0]        tmr_mode_i,
    input  logic [FAST_W-1:0] fast_limit_i,
    output logic              lvl_fast_o,
    output logic              chg_on_o,
    output logic              done_o,
    output logic              tmr_fault_o,
    output logic              fault_cur_o,
    output logic              det_req_o
);
    localparam int PRE_W = $clog2(PRE_LIMIT + 1);
    localparam int SAF_W = (PRE_W > FAST_W) ? PRE_W : FAST_W;
    localparam int DLY_W = $clog2(START_DLY + 1);
    localparam int QUA_W = $clog2(TERM_QUAL + 1);
    localparam logic [SAF_W-1:0] PRE_LIM_V = SAF_W'(PRE_LIMIT);
    localparam logic [DLY_W-1:0] DLY_LIM_V = DLY_W'(START_DLY);
    localparam logic [QUA_W-1:0] QUA_LIM_V = QUA_W'(TERM_QUAL);

    cyc_state_e state_q, state_d;

    logic             lowv_f, term_f;
    logic [DLY_W-1:0] dly_cnt;
    logic [SAF_W-1:0] saf_cnt;
    logic [QUA_W-1:0] qual_cnt;
    logic             charging, fast_ph, tmr_en, fast_to, pre_to, term_ok;
    logic             saf_clr, saf_run, qual_clr;
    cyc_state_e       flt_st;

    // Filtered low-voltage flag (R3) and termination condition (R6)
    dwell_filter #(.N(LOWV_DWELL), .INIT(1'b0)) u_lowv_flt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .raw_i(bat_above_lowv_i), .filt_o(lowv_f)
    );

    dwell_filter #(.N(TERM_DEG), .INIT(1'b0)) u_term_flt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .raw_i(i_below_term_i && !bat_below_rech_i), .filt_o(term_f)
    );

    // Start-up delay counter (R2)
    tick_counter #(.W(DLY_W)) u_dly_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_q != ST_WAIT), .run_i(tick_i), .cnt_o(dly_cnt)
    );

    // Shared safety timer: conditioning limit or fast limit (R4, R5)
    tick_counter #(.W(SAF_W)) u_saf_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr_i(saf_clr), .run_i(saf_run), .cnt_o(saf_cnt)
    );

    // Termination qualification counter (R6)
    tick_counter #(.W(QUA_W)) u_qual_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr_i(qual_clr), .run_i(tick_i && !suspend_i), .cnt_o(qual_cnt)
    );

    always_comb begin
        charging = (state_q == ST_PRE) || (state_q == ST_FAST_CC) || (state_q == ST_CV);
        fast_ph  = (state_q == ST_FAST_CC) || (state_q == ST_CV);
        tmr_en   = (tmr_mode_i != TM_ALL_OFF) && (tmr_mode_i != TM_TMR_OFF);
        fast_to  = tmr_en && (saf_cnt >= SAF_W'(fast_limit_i));
        pre_to   = (saf_cnt >= PRE_LIM_V);
        term_ok  = (tmr_mode_i != TM_ALL_OFF) && (qual_cnt >= QUA_LIM_V);
        flt_st   = bat_below_rech_i ? ST_FLT_LO : ST_FLT_HI;
        saf_run  = tick_i && !suspend_i && charging;
        qual_clr = (state_q != ST_CV) || !term_f || (tmr_mode_i == TM_ALL_OFF);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!chg_en_i) begin
            state_d = ST_IDLE;                                   // R11
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_WAIT;
                ST_WAIT:    if (dly_cnt >= DLY_LIM_V) state_d = ST_RESTART;
                ST_RESTART: state_d = lowv_f ? ST_FAST_CC : ST_PRE;
                ST_PRE: begin
                    if (pre_to)      state_d = flt_st;
                    else if (lowv_f) state_d = ST_FAST_CC;
                end
                ST_FAST_CC: begin
                    if (fast_to)                state_d = flt_st;
                    else if (!lowv_f)           state_d = ST_PRE;
                    else if (!bat_below_rech_i) state_d = ST_CV;
                end
                ST_CV: begin
                    if (fast_to)               state_d = flt_st;
                    else if (!lowv_f)          state_d = ST_PRE;
                    else if (bat_below_rech_i) state_d = ST_FAST_CC;
                    else if (term_ok)          state_d = ST_DONE;
                end
                ST_DONE:   if (bat_below_rech_i)  state_d = ST_RESTART;
                ST_FLT_LO: if (!bat_below_rech_i) state_d = ST_FLT_HI;
                ST_FLT_HI: if (bat_below_rech_i)  state_d = ST_DET;
                ST_DET:    state_d = ST_RESTART;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        saf_clr = (state_q == ST_RESTART)
               || ((state_q == ST_PRE) && (state_d == ST_FAST_CC))
               || (fast_ph && ((state_d == ST_PRE) || (tmr_mode_i == TM_ALL_OFF)));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        lvl_fast_o  = 1'b0;
        chg_on_o    = 1'b0;
        done_o      = 1'b0;
        tmr_fault_o = 1'b0;
        fault_cur_o = 1'b0;
        det_req_o   = 1'b0;
        unique case (state_q)
            ST_PRE:     chg_on_o = !suspend_i;
            ST_FAST_CC,
            ST_CV: begin
                lvl_fast_o = 1'b1;
                chg_on_o   = !suspend_i;
            end
            ST_DONE:    done_o = 1'b1;
            ST_FLT_LO: begin
                tmr_fault_o = 1'b1;
                fault_cur_o = 1'b1;
            end
            ST_FLT_HI:  tmr_fault_o = 1'b1;
            ST_DET:     det_req_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/chg_cycle_chk.sv
module chg_cycle_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_en_i,
    input logic       suspend_i,
    input logic [1:0] tmr_mode_i,
    input logic       chg_on_o,
    input logic       done_o,
    input logic       tmr_fault_o,
    input logic       fault_cur_o,
    input logic       det_req_o
);
    a_r11_en_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en_i |=> (!chg_on_o && !done_o && !tmr_fault_o && !det_req_o));

    a_r2_no_charge_at_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en_i) |=> !chg_on_o);

    a_r4_fault_stops_charge: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fault_o |-> !chg_on_o);

    a_r5_suspend_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |-> !chg_on_o);

    a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!chg_on_o && !tmr_fault_o));

    a_r7_no_term_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(tmr_mode_i, 2) != 2'b00));

    a_r9_det_single: assert property (@(posedge clk) disable iff (!rst_n)
        det_req_o |=> !det_req_o);

    a_r10_faultcur_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cur_o |-> tmr_fault_o);
endmodule

bind chg_cycle_ctrl chg_cycle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chg_en_i(chg_en_i), .suspend_i(suspend_i),
    .tmr_mode_i(tmr_mode_i), .chg_on_o(chg_on_o), .done_o(done_o),
    .tmr_fault_o(tmr_fault_o), .fault_cur_o(fault_cur_o), .det_req_o(det_req_o)
);

// File: tb/chg_cycle_ctrl_bench.sv
module chg_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_DLY  = 6;
    localparam int P_PRE  = 40;
    localparam int P_LOWV = 3;
    localparam int P_TDEG = 2;
    localparam int P_QUAL = 4;
    localparam int P_FW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, en = 1'b0, susp = 1'b0, lowv = 1'b0, rech = 1'b1, ibt = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [P_FW-1:0] flim = 8'd60;
    logic lvl, chg, done, flt, fcur, det;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_cycle_ctrl #(
        .START_DLY(P_DLY), .PRE_LIMIT(P_PRE), .LOWV_DWELL(P_LOWV),
        .TERM_DEG(P_TDEG), .TERM_QUAL(P_QUAL), .FAST_W(P_FW)
    ) u_chg_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .chg_en_i(en), .suspend_i(susp),
        .bat_above_lowv_i(lowv), .bat_below_rech_i(rech), .i_below_term_i(ibt),
        .tmr_mode_i(mode), .fast_limit_i(flim),
        .lvl_fast_o(lvl), .chg_on_o(chg), .done_o(done), .tmr_fault_o(flt),
        .fault_cur_o(fcur), .det_req_o(det)
    );

    // ---------------- requirement model ----------------
    localparam int M_IDLE = 0, M_WAIT = 1, M_RST = 2, M_PRE = 3, M_FCC = 4,
                   M_CV = 5, M_DONE = 6, M_FLO = 7, M_FHI = 8, M_DET = 9;
    int m_st = M_IDLE;
    int m_lv_f = 0, m_lv_c = 0, m_tm_f = 0, m_tm_c = 0;
    int m_dly = 0, m_saf = 0, m_qual = 0;

    function automatic int filt_next_out(int f, int c, int raw, int t, int n);
        if (raw == f) return f;
        if (t != 0 && c == n - 1) return raw;
        return f;
    endfunction

    function automatic int filt_next_cnt(int f, int c, int raw, int t, int n);
        if (raw == f) return 0;
        if (t != 0) return (c == n - 1) ? 0 : c + 1;
        return c;
    endfunction

    function automatic bit exp_chg(int st, logic s);
        return (st == M_PRE || st == M_FCC || st == M_CV) && !s;
    endfunction

    always @(posedge clk) begin
        int nx, tmr_en, fto, flt_st, term_raw, sclr, fast;
        if (!rst_n) begin
            m_st = M_IDLE; m_lv_f = 0; m_lv_c = 0; m_tm_f = 0; m_tm_c = 0;
            m_dly = 0; m_saf = 0; m_qual = 0;
        end else begin
            tmr_en = (mode == 2'b01 || mode == 2'b10);
            fto    = tmr_en && (m_saf >= int'(flim));
            flt_st = rech ? M_FLO : M_FHI;
            fast   = (m_st == M_FCC || m_st == M_CV);
            nx = m_st;
            if (!en) nx = M_IDLE;
            else case (m_st)
                M_IDLE: nx = M_WAIT;
                M_WAIT: if (m_dly >= P_DLY) nx = M_RST;
                M_RST:  nx = m_lv_f ? M_FCC : M_PRE;
                M_PRE:  if (m_saf >= P_PRE) nx = flt_st; else if (m_lv_f != 0) nx = M_FCC;
                M_FCC:  if (fto) nx = flt_st; else if (m_lv_f == 0) nx = M_PRE;
                        else if (!rech) nx = M_CV;
                M_CV:   if (fto) nx = flt_st; else if (m_lv_f == 0) nx = M_PRE;
                        else if (rech) nx = M_FCC;
                        else if (mode != 2'b00 && m_qual >= P_QUAL) nx = M_DONE;
                M_DONE: if (rech) nx = M_RST;
                M_FLO:  if (!rech) nx = M_FHI;
                M_FHI:  if (rech) nx = M_DET;
                M_DET:  nx = M_RST;
                default: nx = M_IDLE;
            endcase
            sclr = (m_st == M_RST) || (m_st == M_PRE && nx == M_FCC) ||
                   (fast && (nx == M_PRE || mode == 2'b00));
            // counters, from pre-edge values
            if (m_st != M_WAIT) m_dly = 0; else if (tick && m_dly < 255) m_dly++;
            if (sclr) m_saf = 0;
            else if (tick && !susp && (m_st == M_PRE || fast) && m_saf < 255) m_saf++;
            if (m_st != M_CV || m_tm_f == 0 || mode == 2'b00) m_qual = 0;
            else if (tick && !susp && m_qual < 7) m_qual++;
            term_raw = (ibt && !rech) ? 1 : 0;
            begin
                int nf, nc;
                nf = filt_next_out(m_lv_f, m_lv_c, int'(lowv), int'(tick), P_LOWV);
                nc = filt_next_cnt(m_lv_f, m_lv_c, int'(lowv), int'(tick), P_LOWV);
                m_lv_f = nf; m_lv_c = nc;
                nf = filt_next_out(m_tm_f, m_tm_c, term_raw, int'(tick), P_TDEG);
                nc = filt_next_cnt(m_tm_f, m_tm_c, term_raw, int'(tick), P_TDEG);
                m_tm_f = nf; m_tm_c = nc;
            end
            m_st = nx;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model, away from the edge
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("R3 level select", lvl, (m_st == M_FCC || m_st == M_CV));
            chk("R5 charge-on",    chg, exp_chg(m_st, susp));
            chk("R6 done",         done, (m_st == M_DONE));
            chk("R4 timer fault",  flt, (m_st == M_FLO || m_st == M_FHI));
            chk("R10 fault current", fcur, (m_st == M_FLO));
            chk("R9 detect request", det, (m_st == M_DET));
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        cmp_on = 1;
        // R1 reset state
        chk("R1 chg", chg, 1'b0); chk("R1 lvl", lvl, 1'b0); chk("R1 done", done, 1'b0);
        chk("R1 flt", flt, 1'b0); chk("R1 fcur", fcur, 1'b0); chk("R1 det", det, 1'b0);
        // R2 start delay
        en = 1'b1;
        wait_cyc(3);
        chk("R2 no charge in delay", chg, 1'b0);
        wait_cyc(12);
        chk("R2 charging after delay", chg, 1'b1);
        chk("R3 conditioning level", lvl, 1'b0);
        // R3 short pulse ignored, long pulse accepted
        lowv = 1'b1; wait_cyc(2); lowv = 1'b0; wait_cyc(4);
        chk("R3 short pulse ignored", lvl, 1'b0);
        lowv = 1'b1; wait_cyc(8);
        chk("R3 fast after dwell", lvl, 1'b1);
        // R6 termination with glitch rejection
        rech = 1'b0; ibt = 1'b1; wait_cyc(1); ibt = 1'b0; wait_cyc(10);
        chk("R6 glitch no done", done, 1'b0);
        ibt = 1'b1; wait_cyc(15);
        chk("R6 done", done, 1'b1);
        chk("R6 charge off", chg, 1'b0);
        // R8 recharge without delay
        rech = 1'b1; ibt = 1'b0; wait_cyc(4);
        chk("R8 recharge charging", chg, 1'b1);
        chk("R8 done cleared", done, 1'b0);
        // R11 enable low, then conditioning timeout
        en = 1'b0; wait_cyc(1);
        chk("R11 idle after enable low", chg, 1'b0);
        lowv = 1'b0; wait_cyc(6); en = 1'b1;
        wait_cyc(P_DLY + P_PRE + 15);
        chk("R4 conditioning timeout", flt, 1'b1);
        chk("R10 fault current below threshold", fcur, 1'b1);
        chk("R4 charge off in fault", chg, 1'b0);
        rech = 1'b0; wait_cyc(3);
        chk("R10 fault current stops", fcur, 1'b0);
        chk("R10 fault still held", flt, 1'b1);
        rech = 1'b1; seen = 0;
        for (int i = 0; i < 6; i++) begin wait_cyc(1); if (det) seen++; end
        chk("R9 single detect pulse", (seen == 1), 1'b1);
        chk("R9 new cycle", chg, 1'b1);
        // R5 fast timer with suspend pause
        lowv = 1'b1; wait_cyc(6);
        flim = 8'd30; susp = 1'b1; wait_cyc(50);
        chk("R5 suspend charge off", chg, 1'b0);
        chk("R5 no fault while paused", flt, 1'b0);
        susp = 1'b0; wait_cyc(40);
        chk("R5 fast timeout", flt, 1'b1);
        // R7 timer modes
        en = 1'b0; mode = 2'b00; flim = 8'd10; wait_cyc(2);
        en = 1'b1; rech = 1'b0; ibt = 1'b1; wait_cyc(80);
        chk("R7 mode00 no done", done, 1'b0);
        chk("R7 mode00 no fault", flt, 1'b0);
        chk("R7 mode00 charging", chg, 1'b1);
        mode = 2'b11; ibt = 1'b0; wait_cyc(40);
        chk("R7 mode11 no fault", flt, 1'b0);
        ibt = 1'b1; wait_cyc(15);
        chk("R7 mode11 terminates", done, 1'b1);
        // constrained random phase checked against the model
        for (int c = 0; c < 30000; c++) begin
            @(negedge clk);
            #1;
            tick = ($urandom % 4) != 0;
            if ($urandom % 400 == 0) en   = ~en;
            if ($urandom % 40  == 0) lowv = ~lowv;
            if ($urandom % 50  == 0) rech = ~rech;
            if ($urandom % 20  == 0) ibt  = ~ibt;
            if ($urandom % 70  == 0) susp = ~susp;
            if ($urandom % 500 == 0) mode = 2'($urandom);
            if ($urandom % 500 == 0) flim = 8'(20 + $urandom % 60);
        end
        wait_cyc(2);
        finish_run();
    end
endmodule